// File: doc/BRIEF.md
# Multiplexed Address/Status Bus Driver

This block sits between a processor core and its external pins. It drives a bus whose low data-width lines are shared between address and data and whose four top lines are shared between the upper address bits and status. Each bus cycle lasts a fixed number of clocks. In the first clock the full address goes out on both groups of lines and an address-latch strobe is high for that one clock, so external latches can capture the address on its falling edge. In the remaining clocks the low lines carry write data, or float on a read so that the addressed device can drive them. The top lines carry status: a two-bit segment code, the interrupt-enable flag captured when the cycle began, and a bus-ownership bit held low.

The core offers a cycle by raising `req_valid` with the address, write data, direction and segment code, and holds these until the strobe rises. Another master asks for the bus with `hold_req`. The request is granted only between cycles. While the grant is up, every shared line floats. Hold wins over a pending cycle request.

Top module: `mbus_drv`

## Requirements
- R1: While reset is applied and on the first clock after it: `ale` low, `ad_oe` low, `hlda` low, `hi_oe` high with `hi_out[3]` (ownership bit) low.
- R2: A bus cycle lasts CYCLE_CLKS clocks. `ale` is high for exactly its first clock. A new cycle starts on the clock edge after `req_valid` is seen high at a cycle boundary (idle, or the last clock of a cycle).
- R3: During the address clock, `ad_out` equals `req_addr[DATA_W-1:0]` and `hi_out` equals `req_addr[DATA_W+3:DATA_W]`, and both `ad_oe` and `hi_oe` are high.
- R4: On a write cycle (`req_write`=1), in every clock after the address clock `ad_oe` is high and `ad_out` equals the write data.
- R5: On a read cycle (`req_write`=0), in every clock after the address clock `ad_oe` is low.
- R6: In every clock after the address clock, `hi_oe` is high and `hi_out` = {S6, S5, S4, S3} from bit 3 down to bit 0. {S4,S3} is `req_seg` (00 extra, 01 stack, 10 code or none, 11 data) and S6 is 0.
- R7: S5 equals `ie_flag` as sampled on the edge that starts the cycle. Changes of `ie_flag` during the cycle do not alter S5.
- R8: A `hold_req` seen at a boundary makes `hlda` high from the next clock. A `hold_req` raised mid-cycle is granted only after that cycle's last clock. While `hlda` is high, `ad_oe`, `hi_oe` and `ale` are all low.
- R9: When `hold_req` falls, `hlda` drops on the next clock and one idle clock follows. A pending `req_valid` does not start a cycle while `hold_req` is high.
- R10: With `req_valid` kept high, cycles follow each other with no idle clock: `ale` rises again in the clock right after the previous cycle's last clock.
- R11: When no cycle runs and no hold is granted, `ale` and `ad_oe` are low, and `hi_oe` is high with `hi_out[3]` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cycle request, held until `ale` rises |
| req_addr | input | DATA_W+4 | Cycle address |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1 write, 0 read |
| req_seg | input | 2 | Segment code for S4:S3 |
| ie_flag | input | 1 | Current interrupt-enable flag |
| hold_req | input | 1 | Bus request from another master |
| hlda | output | 1 | Hold acknowledge |
| ale | output | 1 | Address-latch strobe |
| ad_out | output | DATA_W | Shared low lines, value |
| ad_oe | output | 1 | Shared low lines, drive enable |
| hi_out | output | 4 | Top lines: address high bits or status |
| hi_oe | output | 1 | Top lines, drive enable |

## Verification
The bench builds the block with DATA_W=16 and CYCLE_CLKS=4, giving a 20-bit address and three clocks after the address clock. That is enough to toggle `ie_flag` and raise `hold_req` strictly inside a cycle, and to see the grant wait for the boundary. The short cycle also lets back-to-back cycles and a hold that overlaps a pending request fit in a few dozen clocks. A vector table covers reads and writes with each segment code and both flag values.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_HOLD = 2'd2
    } bus_st_e;

    // Top-line status word, bit 3 down to bit 0
    typedef struct packed {
        logic       own_n;   // S6: low while this master owns the bus
        logic       ie;      // S5: interrupt enable at cycle start
        logic [1:0] seg;     // S4:S3 segment code
    } hi_status_t;

    localparam int HI_W = 4;

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CYCLE_CLKS = 4,
    localparam int AW        = DATA_W + HI_W,
    localparam int PH_W      = (CYCLE_CLKS > 2) ? $clog2(CYCLE_CLKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic [1:0]        req_seg,
    input  logic              ie_flag,
    input  logic              hold_req,
    output bus_st_e           st,
    output logic              first,
    output logic [AW-1:0]     addr,
    output logic [DATA_W-1:0] wdata,
    output logic              wr,
    output logic [1:0]        seg,
    output logic              ie
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYCLE_CLKS - 1);

    typedef struct packed {
        bus_st_e           st;
        logic [PH_W-1:0]   ph;
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        logic [1:0]        seg;
        logic              ie;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic boundary;

    always_comb begin
        nxt_d    = cur_q;
        boundary = (cur_q.st == ST_IDLE) ||
                   (cur_q.st == ST_BUS && cur_q.ph == PH_LAST);
        if (cur_q.st == ST_HOLD) begin
            if (!hold_req) nxt_d.st = ST_IDLE;
        end else if (boundary) begin
            if (hold_req) begin
                nxt_d.st = ST_HOLD;
            end else if (req_valid) begin
                nxt_d.st    = ST_BUS;
                nxt_d.ph    = '0;
                nxt_d.addr  = req_addr;
                nxt_d.wdata = req_wdata;
                nxt_d.wr    = req_write;
                nxt_d.seg   = req_seg;
                nxt_d.ie    = ie_flag;
            end else begin
                nxt_d.st = ST_IDLE;
            end
        end else begin
            nxt_d.ph = cur_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, ph: '0, addr: '0, wdata: '0,
                       wr: 1'b0, seg: 2'b00, ie: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign st    = cur_q.st;
    assign first = (cur_q.st == ST_BUS) && (cur_q.ph == '0);
    assign addr  = cur_q.addr;
    assign wdata = cur_q.wdata;
    assign wr    = cur_q.wr;
    assign seg   = cur_q.seg;
    assign ie    = cur_q.ie;

    // Grant only ever follows a cycle boundary (R8)
    p_hold_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st != ST_HOLD) ##1 (cur_q.st == ST_HOLD) |->
            ($past(cur_q.st) == ST_IDLE) || ($past(cur_q.ph) == PH_LAST));

    // Latched cycle fields do not move inside a cycle (R7)
    p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_BUS && cur_q.ph != PH_LAST) |=>
            $stable(cur_q.ie) && $stable(cur_q.seg) && $stable(cur_q.wr));

endmodule

// File: rtl/mbus_outmux.sv
module mbus_outmux
    import mbus_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int AW    = DATA_W + HI_W
) (
    input  bus_st_e           st,
    input  logic              first,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic [1:0]        seg,
    input  logic              ie,
    output logic              ale,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   hi_out,
    output logic              hi_oe,
    output logic              hlda
);

    hi_status_t stat;

    always_comb begin
        stat.own_n = 1'b0;
        stat.ie    = ie;
        stat.seg   = seg;

        ale    = first;
        hlda   = (st == ST_HOLD);
        hi_oe  = (st != ST_HOLD);
        ad_oe  = (st == ST_BUS) && (first || wr);
        ad_out = first ? addr[DATA_W-1:0] : wdata;
        hi_out = first ? addr[AW-1:DATA_W] : stat;
    end

endmodule

// File: rtl/mbus_drv.sv
module mbus_drv
    import mbus_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CYCLE_CLKS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [DATA_W+HI_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_write,
    input  logic [1:0]               req_seg,
    input  logic                     ie_flag,
    input  logic                     hold_req,
    output logic                     hlda,
    output logic                     ale,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [HI_W-1:0]          hi_out,
    output logic                     hi_oe
);

    localparam int AW = DATA_W + HI_W;

    bus_st_e           s_st;
    logic              s_first;
    logic [AW-1:0]     s_addr;
    logic [DATA_W-1:0] s_wdata;
    logic              s_wr;
    logic [1:0]        s_seg;
    logic              s_ie;

    mbus_seq #(.DATA_W(DATA_W), .CYCLE_CLKS(CYCLE_CLKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_seg   (req_seg),
        .ie_flag   (ie_flag),
        .hold_req  (hold_req),
        .st        (s_st),
        .first     (s_first),
        .addr      (s_addr),
        .wdata     (s_wdata),
        .wr        (s_wr),
        .seg       (s_seg),
        .ie        (s_ie)
    );

    mbus_outmux #(.DATA_W(DATA_W)) u_mux (
        .st     (s_st),
        .first  (s_first),
        .addr   (s_addr),
        .wdata  (s_wdata),
        .wr     (s_wr),
        .seg    (s_seg),
        .ie     (s_ie),
        .ale    (ale),
        .ad_out (ad_out),
        .ad_oe  (ad_oe),
        .hi_out (hi_out),
        .hi_oe  (hi_oe),
        .hlda   (hlda)
    );

    // Strobe lasts a single clock (R2)
    p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // Everything floats while another master owns the bus (R8)
    p_float_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ad_oe && !hi_oe && !ale));

    // Ownership bit low whenever top lines carry status (R6)
    p_s6_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_oe && !ale) |-> !hi_out[3]);

    // Enable flag shown as S5 holds across the data clocks (R7)
    p_s5_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && !hlda && ad_oe) |=> (ad_oe && !ale) |-> $stable(hi_out[2]));

    // Grant never arrives while strobe is up (R8)
    p_no_grant_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !hlda);

endmodule

// File: tb/mbus_drv_tb.sv
module mbus_drv_tb;

    localparam int DW   = 16;
    localparam int NCLK = 4;
    localparam int AW   = DW + 4;
    localparam int NV   = 6;
    localparam int VW   = AW + DW + 1 + 2 + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_write = 1'b0;
    logic [1:0]    req_seg = 2'b00;
    logic          ie_flag = 1'b0;
    logic          hold_req = 1'b0;
    logic          hlda, ale, ad_oe, hi_oe;
    logic [DW-1:0] ad_out;
    logic [3:0]    hi_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mbus_drv #(.DATA_W(DW), .CYCLE_CLKS(NCLK)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_seg(req_seg),
        .ie_flag(ie_flag), .hold_req(hold_req), .hlda(hlda), .ale(ale),
        .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out), .hi_oe(hi_oe)
    );

    // {addr, wdata, write, seg, ie}
    localparam logic [VW-1:0] VEC [0:NV-1] = '{
        {20'hA1234, 16'hBEEF, 1'b1, 2'b00, 1'b1},
        {20'h5F00F, 16'h0000, 1'b0, 2'b01, 1'b0},
        {20'hFFFFF, 16'h55AA, 1'b1, 2'b10, 1'b0},
        {20'h00000, 16'h1357, 1'b0, 2'b11, 1'b1},
        {20'h3C3C3, 16'hFFFF, 1'b1, 2'b11, 1'b0},
        {20'hC0DE1, 16'h2468, 1'b0, 2'b10, 1'b1}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_check(input string tag);
        check(!ale && !ad_oe && hi_oe && !hi_out[3] && !hlda, tag,
              {ale, ad_oe, hi_oe, hi_out[3], hlda}, 5'b00100);
    endtask

    // Drives one cycle starting at a negedge; returns at negedge after last clock
    task automatic run_cycle(input logic [VW-1:0] v, input bit keep_valid);
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic w, ie;
        logic [1:0] sg;
        {a, d, w, sg, ie} = v;
        req_valid = 1'b1; req_addr = a; req_wdata = d; req_write = w;
        req_seg = sg; ie_flag = ie;
        @(negedge clk);
        check(ale, "R2 strobe on address clock", 32'(ale), 1);
        check(ad_oe && ad_out == a[DW-1:0], "R3 low lines carry address",
              32'(ad_out), 32'(a[DW-1:0]));
        check(hi_oe && hi_out == a[AW-1:DW], "R3 top lines carry address",
              32'(hi_out), 32'(a[AW-1:DW]));
        if (!keep_valid) req_valid = 1'b0;
        ie_flag = ~ie;
        for (int p = 1; p < NCLK; p++) begin
            @(negedge clk);
            check(!ale, "R2 strobe low after first clock", 32'(ale), 0);
            if (w)
                check(ad_oe && ad_out == d, "R4 write data driven",
                      {15'b0, ad_oe, ad_out}, {15'b0, 1'b1, d});
            else
                check(!ad_oe, "R5 read floats low lines", 32'(ad_oe), 0);
            check(hi_oe && hi_out == {1'b0, ie, sg}, "R6 R7 status word",
                  32'(hi_out), 32'({1'b0, ie, sg}));
            ie_flag = ie ^ p[0];
        end
    endtask

    initial begin
        #(8 * 5000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(!ale && !ad_oe && !hlda && hi_oe && !hi_out[3], "R1 in reset",
              {ale, ad_oe, hlda, hi_oe, hi_out[3]}, 5'b00010);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ale && !ad_oe && !hlda && hi_oe && !hi_out[3], "R1 after reset",
              {ale, ad_oe, hlda, hi_oe, hi_out[3]}, 5'b00010);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            run_cycle(VEC[i], 1'b0);
            @(negedge clk);
            idle_check("R11 idle between cycles");
        end

        // R10 back-to-back
        run_cycle(VEC[0], 1'b1);
        run_cycle(VEC[1], 1'b0);
        @(negedge clk);
        idle_check("R10 R11 idle after chain");

        // R8 hold from idle
        hold_req = 1'b1;
        @(negedge clk);
        check(hlda && !ad_oe && !hi_oe && !ale, "R8 grant from idle floats",
              {hlda, ad_oe, hi_oe, ale}, 4'b1000);
        // R9 request pending during hold is held off
        req_valid = 1'b1; req_addr = 20'h12345; req_write = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(hlda && !ale, "R9 no cycle while hold", {hlda, ale}, 2'b10);
        end
        hold_req = 1'b0;
        @(negedge clk);
        check(!hlda && !ale && hi_oe && !hi_out[3], "R9 release gives idle clock",
              {hlda, ale, hi_oe, hi_out[3]}, 4'b0010);
        @(negedge clk);
        check(ale && ad_out == 16'h2345, "R9 pending cycle starts after",
              32'(ad_out), 32'h2345);
        req_valid = 1'b0;
        repeat (NCLK) @(negedge clk);
        idle_check("R11 idle after resumed cycle");

        // R8 hold raised mid-cycle waits for boundary
        req_valid = 1'b1; req_addr = VEC[2][VW-1 -: AW]; req_write = 1'b1;
        req_wdata = 16'h0F0F;
        @(negedge clk);
        req_valid = 1'b0;
        hold_req = 1'b1;
        for (int p = 1; p < NCLK; p++) begin
            @(negedge clk);
            check(!hlda && ad_oe && ad_out == 16'h0F0F, "R8 cycle finishes before grant",
                  {15'b0, hlda, ad_out}, {16'b0, 16'h0F0F});
        end
        @(negedge clk);
        check(hlda && !ad_oe && !hi_oe, "R8 grant at boundary",
              {hlda, ad_oe, hi_oe}, 3'b100);
        hold_req = 1'b0;
        @(negedge clk);
        check(!hlda && hi_oe, "R9 grant drops next clock", {hlda, hi_oe}, 2'b01);
        @(negedge clk);
        idle_check("R11 idle after hold");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule